// File: doc/BRIEF.md
# Receive Framer Error Counter Bank

This block keeps running totals of the receive-side error events that a T1/E1 framer reports. Each error class has its own wraparound counter of fixed width: a 12-bit counter of framing-bit errors, a 10-bit counter of CRC errors and a 10-bit counter of far-end block errors. Single-cycle strobes from the framer advance the counters. The frame counter can also take the Fs (T1) or NFAS (E1) error strobe when a configuration input asks for it.

A processor reads each counter as two bytes through a small register window. Reading the low byte returns the low eight bits, stores the upper bits in a hold register and clears the counter. A later read of the high byte returns the stored bits, so the two bytes always come from the same instant. When a counter wraps, it sets its own bit in a shared overflow status byte. That bit stays set until the status byte is read. Each status bit has a mask bit, and the interrupt output is the OR of the unmasked status bits.

Top module: `err_cnt_bank`

## Requirements
- R1: The frame counter advances by one for each cycle with `frm_err_i` high. `fs_err_i` adds one to it only in a cycle where `incl_fs_i` is high, and has no effect otherwise.
- R2: When `frm_err_i` and an included `fs_err_i` are both high in one cycle, the frame counter advances by two.
- R3: The CRC counter is 10 bits wide and advances by one for each cycle with `crc_err_i` high.
- R4: The far-end block error counter is 10 bits wide and advances by one for each cycle with `febe_err_i` high.
- R5: Each counter counts modulo 2^width (4096 for the frame counter, 1024 for the other two). When an increment passes the top, the counter wraps and its status bit is set in the same cycle: bit 0 for frame, bit 1 for CRC, bit 2 for far-end block.
- R6: A status bit stays set until a read of address 6. That read returns the status byte on `rd_data_o` in bits [2:0] and clears the bits. A wrap in the same cycle as the read still sets its bit.
- R7: A read of a low-byte address (0 frame, 2 CRC, 4 far-end block) puts bits [7:0] of the counter on `rd_data_o` one cycle later. The same read loads the counter's upper bits into its hold register and clears the counter. Strobes in the reading cycle are counted from zero. `rd_data_o` keeps its value until the next read.
- R8: A read of a high-byte address (1 frame, 3 CRC, 5 far-end block) returns that counter's hold register, zero-extended, one cycle later. It leaves the counter unchanged.
- R9: `irq_o` is high exactly when some status bit is set and its bit in `irq_mask_i` is 0. It follows the status and the mask without extra delay.
- R10: After reset, all counters, hold registers, status bits, `rd_data_o` and `irq_o` are zero.
- R11: A read of address 7 returns zero and changes no counter, hold register or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_err_i | input | 1 | Framing-bit error strobe |
| fs_err_i | input | 1 | Fs / NFAS error strobe |
| crc_err_i | input | 1 | CRC error strobe |
| febe_err_i | input | 1 | Far-end block error strobe |
| incl_fs_i | input | 1 | Adds Fs / NFAS errors into the frame counter |
| rd_en_i | input | 1 | Register read request, one cycle |
| rd_addr_i | input | 3 | Register address |
| irq_mask_i | input | 3 | Per-bit mask of the overflow status |
| rd_data_o | output | 8 | Read data, valid the cycle after the request |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A strobe at clock edge k is already in the counter after edge k. A wrap sets its status bit at that same edge. `irq_o` follows a status or mask change in the same cycle with no register between them. Read data appears on `rd_data_o` after the edge that takes the request. The bench updates its behavioural model at each rising edge from inputs driven at the previous falling edge. It then compares `rd_data_o` and `irq_o` a quarter period after the edge, so each result is checked in the cycle it is due. Directed reads after long runs of strobes check the wrap and double-step corners against constants worked out by hand.

// File: rtl/cbank_pkg.sv
package cbank_pkg;

    localparam int N_CNT  = 3;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_FRM_LO  = 3'd0,
        A_FRM_HI  = 3'd1,
        A_CRC_LO  = 3'd2,
        A_CRC_HI  = 3'd3,
        A_FEBE_LO = 3'd4,
        A_FEBE_HI = 3'd5,
        A_STATUS  = 3'd6,
        A_SPARE   = 3'd7
    } reg_addr_e;

    typedef logic [1:0] step_t;

endpackage

// File: rtl/err_counter.sv
module err_counter
    import cbank_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_t        inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = (clr_i ? '0 : {1'b0, st_q.cnt}) + (W+1)'(inc_i);
        st_d.cnt = sum[W-1:0];
        wrap_o = sum[W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R7: a snapshot read with no strobe leaves the counter empty
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && inc_i == 2'd0) |=> (cnt_o == '0));

    // R5: a wrap leaves only the carried remainder
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o < W'(2)));

    // R8: without strobe or clear the count holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i == 2'd0) |=> $stable(cnt_o));

endmodule

// File: rtl/ovf_status.sv
module ovf_status
    import cbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] set_i,
    input  logic             clr_i,
    input  logic [N_CNT-1:0] mask_i,
    output logic [N_CNT-1:0] sts_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [N_CNT-1:0] sts;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sts = (clr_i ? '0 : st_q.sts) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
    assign irq_o = |(st_q.sts & ~mask_i);

    // R6: status bits are sticky until the status read
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

    // R5 / R6: a wrap always lands, even during the status read
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
    import cbank_pkg::*;
#(
    parameter int FRM_W  = 12,
    parameter int CRC_W  = 10,
    parameter int FEBE_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_err_i,
    input  logic        fs_err_i,
    input  logic        crc_err_i,
    input  logic        febe_err_i,
    input  logic        incl_fs_i,
    input  logic        rd_en_i,
    input  logic [2:0]  rd_addr_i,
    input  logic [2:0]  irq_mask_i,
    output logic [7:0]  rd_data_o,
    output logic        irq_o
);

    localparam int CW [N_CNT] = '{FRM_W, CRC_W, FEBE_W};

    typedef struct packed {
        logic [7:0]            rd;
        logic [N_CNT-1:0][7:0] hold;
    } top_state_t;

    top_state_t st_d, st_q;

    step_t [N_CNT-1:0]       inc;
    logic  [N_CNT-1:0]       clr_cnt;
    logic  [N_CNT-1:0]       wrap;
    logic  [N_CNT-1:0][15:0] cnt_all;
    logic  [N_CNT-1:0]       sts;
    logic                    clr_sts;
    reg_addr_e               addr;

    always_comb begin
        inc[0] = step_t'(frm_err_i) + step_t'(fs_err_i & incl_fs_i);
        inc[1] = step_t'(crc_err_i);
        inc[2] = step_t'(febe_err_i);
    end

    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
            logic [CW[i]-1:0] c;
            err_counter #(.W(CW[i])) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc_i  (inc[i]),
                .clr_i  (clr_cnt[i]),
                .cnt_o  (c),
                .wrap_o (wrap[i])
            );
            assign cnt_all[i] = 16'(c);
        end
    endgenerate

    ovf_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wrap),
        .clr_i  (clr_sts),
        .mask_i (irq_mask_i),
        .sts_o  (sts),
        .irq_o  (irq_o)
    );

    always_comb begin
        st_d    = st_q;
        clr_cnt = '0;
        clr_sts = 1'b0;
        addr    = reg_addr_e'(rd_addr_i);
        if (rd_en_i) begin
            unique case (addr)
                A_FRM_LO, A_CRC_LO, A_FEBE_LO: begin
                    st_d.rd                 = cnt_all[rd_addr_i[2:1]][7:0];
                    st_d.hold[rd_addr_i[2:1]] = cnt_all[rd_addr_i[2:1]][15:8];
                    clr_cnt[rd_addr_i[2:1]]   = 1'b1;
                end
                A_FRM_HI, A_CRC_HI, A_FEBE_HI: begin
                    st_d.rd = st_q.hold[rd_addr_i[2:1]];
                end
                A_STATUS: begin
                    st_d.rd = 8'(sts);
                    clr_sts = 1'b1;
                end
                default: st_d.rd = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rd;

    // R11: the spare address reads as zero
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == 3'd7) |=> (rd_data_o == 8'h00));

    // R9: an interrupt needs an unmasked status bit
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((sts & ~irq_mask_i) != '0));

    // R1: an excluded Fs strobe alone leaves the frame count alone
    p_fs_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_err_i && !incl_fs_i && !(rd_en_i && rd_addr_i == 3'd0))
        |=> $stable(cnt_all[0]));

endmodule

// File: tb/tb_err_cnt_bank.sv
module tb_err_cnt_bank;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_err = 0, fs_err = 0, crc_err = 0, febe_err = 0, incl_fs = 0;
    logic       rd_en = 0;
    logic [2:0] rd_addr = 3'd7;
    logic [2:0] mask = 3'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt [3];
    int m_hold [3];
    int m_sts;
    int m_rd;
    int lim [3] = '{4096, 1024, 1024};

    err_cnt_bank dut (
        .clk(clk), .rst_n(rst_n), .frm_err_i(frm_err), .fs_err_i(fs_err),
        .crc_err_i(crc_err), .febe_err_i(febe_err), .incl_fs_i(incl_fs),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .irq_mask_i(mask),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model update at each rising edge, comparison a quarter period later
    always begin
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_hold[i] = 0; end
            m_sts = 0; m_rd = 0;
        end else begin
            int add [3];
            bit clr [3];
            bit clr_s;
            add[0] = int'(frm_err) + ((incl_fs && fs_err) ? 1 : 0);
            add[1] = int'(crc_err);
            add[2] = int'(febe_err);
            for (int i = 0; i < 3; i++) clr[i] = 0;
            clr_s = 0;
            if (rd_en) begin
                case (rd_addr)
                    3'd0, 3'd2, 3'd4: begin
                        m_rd = m_cnt[rd_addr/2] % 256;
                        m_hold[rd_addr/2] = m_cnt[rd_addr/2] / 256;
                        clr[rd_addr/2] = 1;
                    end
                    3'd1, 3'd3, 3'd5: m_rd = m_hold[rd_addr/2];
                    3'd6: begin m_rd = m_sts; clr_s = 1; end
                    default: m_rd = 0;
                endcase
            end
            if (clr_s) m_sts = 0;
            for (int i = 0; i < 3; i++) begin
                if (clr[i]) m_cnt[i] = 0;
                m_cnt[i] += add[i];
                if (m_cnt[i] >= lim[i]) begin
                    m_cnt[i] -= lim[i];
                    m_sts |= (1 << i);
                end
            end
        end
        #(CLK_P/4);
        chk("R7 rd_data", int'(rd_data), m_rd);
        chk("R9 irq", int'(irq), ((m_sts & ~int'(mask)) != 0) ? 1 : 0);
    end

    task automatic cyc(bit f, bit s, bit c, bit b, bit r, int a);
        @(negedge clk);
        frm_err = f; fs_err = s; crc_err = c; febe_err = b;
        rd_en = r; rd_addr = 3'(a);
    endtask

    task automatic rd(int a, output int v);
        cyc(0, 0, 0, 0, 1, a);
        cyc(0, 0, 0, 0, 0, 7);
        v = int'(rd_data);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 rd_data", int'(rd_data), 0);
        chk("R10 irq", int'(irq), 0);
        rd(6, v); chk("R10 status", v, 0);
        rd(0, v); chk("R10 frame lo", v, 0);

        // R1: Fs strobes excluded, then included
        incl_fs = 0;
        repeat (5) cyc(1, 0, 0, 0, 0, 7);
        repeat (4) cyc(0, 1, 0, 0, 0, 7);
        rd(0, v); chk("R1 frame excl", v, 5);
        incl_fs = 1;
        repeat (3) cyc(0, 1, 0, 0, 0, 7);
        rd(0, v); chk("R1 frame incl", v, 3);

        // R2: both strobes in one cycle count twice
        repeat (6) cyc(1, 1, 0, 0, 0, 7);
        rd(0, v); chk("R2 double step", v, 12);

        // R3 / R4 / R8: 10-bit counters and high byte
        repeat (700) cyc(0, 0, 1, 0, 0, 7);
        repeat (300) cyc(0, 0, 0, 1, 0, 7);
        rd(2, v); chk("R3 crc lo", v, 700 % 256);
        rd(3, v); chk("R8 crc hi", v, 700 / 256);
        rd(4, v); chk("R4 febe lo", v, 300 % 256);
        rd(5, v); chk("R8 febe hi", v, 300 / 256);
        rd(3, v); chk("R8 hi repeat", v, 700 / 256);

        // R7: strobe during the snapshot read restarts from one
        repeat (10) cyc(0, 0, 1, 0, 0, 7);
        cyc(0, 0, 1, 0, 1, 2);
        cyc(0, 0, 0, 0, 0, 7);
        chk("R7 snapshot", int'(rd_data), 10);
        rd(2, v); chk("R7 count after clear", v, 1);

        // R5 / R9 / R6: frame wrap through 4095 by a double step
        incl_fs = 0;
        repeat (4095) cyc(1, 0, 0, 0, 0, 7);
        mask = 3'b001;
        rd(0, v); chk("R5 frame 4095 lo", v, 255);
        rd(1, v); chk("R8 frame 4095 hi", v, 15);
        chk("R9 no irq", int'(irq), 0);
        repeat (4095) cyc(1, 0, 0, 0, 0, 7);
        incl_fs = 1;
        cyc(1, 1, 0, 0, 0, 7);
        cyc(0, 0, 0, 0, 0, 7);
        chk("R9 masked", int'(irq), 0);
        mask = 3'b000;
        #1;
        chk("R9 unmasked", int'(irq), 1);
        rd(0, v); chk("R5 frame wrapped", v, 1);
        // R6: sticky, then cleared; set wins over same-cycle clear
        chk("R6 sticky irq", int'(irq), 1);
        repeat (1023) cyc(0, 0, 0, 1, 0, 7);
        cyc(0, 0, 0, 1, 1, 6);
        cyc(0, 0, 0, 0, 0, 7);
        chk("R6 status read", int'(rd_data), 1);
        rd(6, v); chk("R6 set wins", v, 4);
        rd(6, v); chk("R6 cleared", v, 0);

        // R11: spare address has no side effect
        repeat (9) cyc(0, 0, 0, 1, 0, 7);
        rd(7, v); chk("R11 spare", v, 0);
        rd(4, v); chk("R11 count kept", v, 9);

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            int a;
            a = int'($urandom_range(0, 7));
            if (k % 97 == 0) incl_fs = ~incl_fs;
            if (k % 53 == 0) mask = 3'($urandom_range(0, 7));
            cyc(($urandom_range(0, 3) != 0), $urandom_range(0, 1) == 1,
                $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 15) == 0, a);
        end
        cyc(0, 0, 0, 0, 0, 7);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule